// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit with Condition Evaluator

This block is the arithmetic core of a small processor datapath. It adds or subtracts two operands and always presents the result on its output in the same cycle. It can also keep the outcome in a four-bit status register of negative, zero, carry and overflow flags. The status register changes only when the caller asks for a flag-setting operation. When that happens, the new flags are captured on the next rising clock edge.

Next to the arithmetic sits a condition evaluator. It takes a four-bit condition code and reports whether an instruction guarded by that condition should run. It looks only at the flags already held in the status register, never at the operation being applied in the same cycle. This lets a non-flag-setting operation sit between a compare and a conditional branch without disturbing the branch decision.

Top module: `alu_flag_core`

## Requirements
- R1: While `rst_n` is low, the four stored flags are 0; reset is asynchronous.
- R2: `result` equals `opnd_a + opnd_b` when `op_sub` is 0 and `opnd_a - opnd_b` when `op_sub` is 1, modulo 2^DATA_W, in the same cycle, whatever the value of `set_flags`.
- R3: A rising clock edge with `set_flags` low leaves all four stored flags unchanged, including when the result is zero.
- R4: A rising clock edge with `set_flags` high stores N = result bit DATA_W-1 and Z = 1 exactly when the result is all zeros.
- R5: On a flag-setting add, C is stored as the unsigned carry out of the top bit. V is stored as 1 when both operands have the same sign and the result sign differs from it.
- R6: On a flag-setting subtract, C is stored as 1 exactly when `opnd_a` is unsigned-greater-than-or-equal to `opnd_b` (no borrow). V is stored as 1 when the operand signs differ and the result sign differs from that of `opnd_a`.
- R7: `cond_pass` is computed from the stored flags only. In the cycle a flag-setting operation is applied, it still reflects the flags from before that operation.
- R8: The single-flag codes are 0 = Z set, 1 = Z clear, 2 = C set, 3 = C clear, 4 = N set, 5 = N clear, 6 = V set and 7 = V clear.
- R9: The compound codes are as follows. Code 8 needs C set and Z clear. Code 9 needs C clear or Z set. Code 10 needs N equal to V. Code 11 needs N different from V. Code 12 needs Z clear and N equal to V. Code 13 needs Z set or N different from V.
- R10: Codes 14 and 15 always give `cond_pass` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| set_flags | input | 1 | Store the new flags at the next edge |
| cond_code | input | 4 | Condition to evaluate against the stored flags |
| result | output | DATA_W | Sum or difference |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_v | output | 1 | Stored signed overflow flag |
| cond_pass | output | 1 | Guarded instruction should execute |

## Verification
The bench builds the block with its default DATA_W of 32. This puts the real sign boundaries within reach: 0x7FFFFFFF + 1, 0xFFFFFFFF + 1, 0 - 1, 0x80000000 - 1 and 1 - 0x80000000. Between them, these drive every flag to both values. After each of these flag states, all sixteen condition codes are swept, so each compound condition is seen both passing and failing. A zero-result subtract without flag setting, followed by a not-equal check, shows that the stored Z is the one consulted. A run of random operations and a reset in the middle of the run round out the test.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [3:0] {
        COND_ZSET   = 4'h0,
        COND_ZCLR   = 4'h1,
        COND_CSET   = 4'h2,
        COND_CCLR   = 4'h3,
        COND_NSET   = 4'h4,
        COND_NCLR   = 4'h5,
        COND_VSET   = 4'h6,
        COND_VCLR   = 4'h7,
        COND_UHI    = 4'h8,
        COND_ULS    = 4'h9,
        COND_SGE    = 4'hA,
        COND_SLT    = 4'hB,
        COND_SGT    = 4'hC,
        COND_SLE    = 4'hD,
        COND_ALWAYS = 4'hE,
        COND_ALT    = 4'hF
    } cond_e;

    localparam flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output flags_t            flags_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide_sum;

    // Subtraction reuses the adder: a + ~b + 1.
    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        sum_o    = wide_sum[MSB:0];
        flags_o.n = wide_sum[MSB];
        flags_o.z = ~|wide_sum[MSB:0];
        flags_o.c = wide_sum[DATA_W];
        flags_o.v = (a_i[MSB] == b_eff[MSB]) && (wide_sum[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t d_i,
    output flags_t q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= FLAGS_CLEAR;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
    import alu_flag_pkg::*;
(
    input  flags_t     flags_i,
    input  logic [3:0] code_i,
    output logic       pass_o
);

    cond_e code;
    logic  sign_ok;

    always_comb begin
        code    = cond_e'(code_i);
        sign_ok = (flags_i.n == flags_i.v);
        pass_o  = 1'b0;
        unique case (code)
            COND_ZSET:   pass_o = flags_i.z;
            COND_ZCLR:   pass_o = ~flags_i.z;
            COND_CSET:   pass_o = flags_i.c;
            COND_CCLR:   pass_o = ~flags_i.c;
            COND_NSET:   pass_o = flags_i.n;
            COND_NCLR:   pass_o = ~flags_i.n;
            COND_VSET:   pass_o = flags_i.v;
            COND_VCLR:   pass_o = ~flags_i.v;
            COND_UHI:    pass_o = flags_i.c & ~flags_i.z;
            COND_ULS:    pass_o = ~flags_i.c | flags_i.z;
            COND_SGE:    pass_o = sign_ok;
            COND_SLT:    pass_o = ~sign_ok;
            COND_SGT:    pass_o = ~flags_i.z & sign_ok;
            COND_SLE:    pass_o = flags_i.z | ~sign_ok;
            COND_ALWAYS: pass_o = 1'b1;
            COND_ALT:    pass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              op_sub,
    input  logic              set_flags,
    input  logic [3:0]        cond_code,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              cond_pass
);

    flags_t next_flags;
    flags_t held_flags;

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .sub_i   (op_sub),
        .sum_o   (result),
        .flags_o (next_flags)
    );

    alu_flag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (set_flags),
        .d_i    (next_flags),
        .q_o    (held_flags)
    );

    alu_cond_eval u_cond (
        .flags_i (held_flags),
        .code_i  (cond_code),
        .pass_o  (cond_pass)
    );

    assign flag_n = held_flags.n;
    assign flag_z = held_flags.z;
    assign flag_c = held_flags.c;
    assign flag_v = held_flags.v;

endmodule

// File: rtl/alu_flag_core_chk.sv
module alu_flag_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              op_sub,
    input logic              set_flags,
    input logic [3:0]        cond_code,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v,
    input logic              cond_pass
);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000 || rst_n));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    a_r4_nz_capture: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> (flag_n == $past(result[DATA_W-1])) &&
                      (flag_z == ($past(result) == '0)));

    a_r6_sub_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && op_sub) |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))));

    a_r8_zero_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code == 4'h0 || cond_code == 4'h1) |->
            (cond_pass == (flag_z ^ cond_code[0])));

    a_r10_always: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[3:1] == 3'b111) |-> cond_pass);

endmodule

bind alu_flag_core alu_flag_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .op_sub    (op_sub),
    .set_flags (set_flags),
    .cond_code (cond_code),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v),
    .cond_pass (cond_pass)
);

// File: tb/alu_flag_core_bench.sv
module alu_flag_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] opnd_a, opnd_b;
    logic         op_sub, set_flags;
    logic [3:0]   cond_code;
    logic [W-1:0] result;
    logic         flag_n, flag_z, flag_c, flag_v, cond_pass;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_flag_core #(.DATA_W(W)) u_alu_flag_core (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sub(op_sub), .set_flags(set_flags), .cond_code(cond_code),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .flag_v(flag_v), .cond_pass(cond_pass)
    );

    typedef struct {
        string        tag;
        logic [W-1:0] res;
        logic [3:0]   flg;
        logic         pass;
    } item_t;

    item_t sb_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    logic  [3:0] m_flags = 4'b0000;   // {n,z,c,v}
    event  chk_ev;

    function automatic logic [W+3:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic sub);
        logic [W-1:0] r;
        logic [W:0]   t;
        logic         c, v;
        longint       sa, sb, s, maxp, minn;
        sa   = longint'($signed(a));
        sb   = longint'($signed(b));
        maxp = (longint'(1) <<< (W-1)) - 1;
        minn = -(longint'(1) <<< (W-1));
        if (sub) begin
            r = a - b;
            c = (a >= b);
            s = sa - sb;
        end else begin
            t = {1'b0, a} + {1'b0, b};
            r = t[W-1:0];
            c = t[W];
            s = sa + sb;
        end
        v = (s > maxp) || (s < minn);
        return {r, r[W-1], (r == '0), c, v};
    endfunction

    function automatic logic cond_model(input logic [3:0] cc, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'h0: return z;
            4'h1: return !z;
            4'h2: return c;
            4'h3: return !c;
            4'h4: return n;
            4'h5: return !n;
            4'h6: return v;
            4'h7: return !v;
            4'h8: return c && !z;
            4'h9: return !c || z;
            4'hA: return n == v;
            4'hB: return n != v;
            4'hC: return !z && (n == v);
            4'hD: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                        input logic sf, input logic [3:0] cc, input string tag);
        logic [W+3:0] m;
        item_t it;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sub = sub; set_flags = sf; cond_code = cc;
        #1;
        m = model(a, b, sub);
        it.tag  = tag;
        it.res  = m[W+3:4];
        it.flg  = m_flags;
        it.pass = cond_model(cc, m_flags);
        sb_q.push_back(it);
        ->chk_ev;
        if (sf) m_flags = m[3:0];
    endtask

    function automatic string cc_tag(input logic [3:0] cc);
        if (cc < 4'h8) return "R8";
        if (cc < 4'hE) return "R9";
        return "R10";
    endfunction

    task automatic sweep_codes(input string flag_tag);
        for (int i = 0; i < 16; i++) begin
            step(32'd1, 32'd1, 1'b0, 1'b0, 4'(i), {flag_tag, " ", cc_tag(4'(i))});
        end
    endtask

    // Monitor: pops expected items and compares with the design.
    initial begin
        item_t it;
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_tests++;
                if (result !== it.res) begin
                    n_fail++;
                    $display("FAIL %s result: actual=%h expected=%h", it.tag, result, it.res);
                end
                n_tests++;
                if ({flag_n, flag_z, flag_c, flag_v} !== it.flg) begin
                    n_fail++;
                    $display("FAIL %s flags: actual=%b expected=%b", it.tag,
                             {flag_n, flag_z, flag_c, flag_v}, it.flg);
                end
                n_tests++;
                if (cond_pass !== it.pass) begin
                    n_fail++;
                    $display("FAIL %s cond_pass(code %h): actual=%b expected=%b", it.tag,
                             cond_code, cond_pass, it.pass);
                end
            end
        end
    end

    task automatic check_reset_flags(input string tag);
        n_tests++;
        if ({flag_n, flag_z, flag_c, flag_v} !== 4'b0000) begin
            n_fail++;
            $display("FAIL %s flags in reset: actual=%b expected=0000", tag,
                     {flag_n, flag_z, flag_c, flag_v});
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; opnd_a = '0; opnd_b = '0; op_sub = 1'b0;
        set_flags = 1'b0; cond_code = 4'h0;
        repeat (2) @(negedge clk);
        check_reset_flags("R1");
        rst_n = 1'b1;

        step(32'd5, 32'd7, 1'b0, 1'b0, 4'h1, "R2");
        step(32'd5, 32'd5, 1'b1, 1'b1, 4'h0, "R4 R6 R7");
        // plain subtract giving zero: NE must see the older Z=1
        step(32'd3, 32'd3, 1'b1, 1'b0, 4'h1, "R3 R7");
        step(32'd9, 32'd2, 1'b1, 1'b0, 4'h0, "R3");
        step(32'h7FFF_FFFF, 32'd1, 1'b0, 1'b1, 4'hE, "R5 R7");
        sweep_codes("R5");
        step(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, 4'hF, "R4 R5");
        sweep_codes("R4");
        step(32'd0, 32'd1, 1'b1, 1'b1, 4'h3, "R6");
        sweep_codes("R6");
        step(32'h8000_0000, 32'd1, 1'b1, 1'b1, 4'h6, "R6");
        sweep_codes("R6");
        step(32'd1, 32'h8000_0000, 1'b1, 1'b1, 4'hA, "R6");
        sweep_codes("R6");

        for (int i = 0; i < 60; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = (i % 7 == 0) ? ra : $urandom();
            step(ra, rb, 1'($urandom()), 1'($urandom()), 4'($urandom()), "R2 R3 R4");
        end

        // mid-run reset after flags are non-zero
        step(32'd0, 32'd1, 1'b1, 1'b1, 4'h0, "R6");
        @(negedge clk);
        set_flags = 1'b0;
        rst_n = 1'b0;
        #1;
        check_reset_flags("R1");
        m_flags = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;
        step(32'd4, 32'd4, 1'b1, 1'b0, 4'h1, "R1 R3");
        step(32'd0, 32'd0, 1'b0, 1'b0, 4'hE, "R10");

        @(negedge clk);
        #1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule